// File: doc/BRIEF.md
# Dual PLL Lock-Loss Interrupt Monitor

This block watches the lock indicators of two PLLs: a system PLL on source 0 and a USB PLL on source 1. It raises one shared, level-sensitive interrupt request when a PLL that had already reached lock drops out of lock. A PLL that is still acquiring lock for the first time never raises the interrupt. Each lock input may be asynchronous to the block clock, so each one passes through a synchronizer before any edge is examined.

Software reads per-source sticky flags to find which PLL slipped. It clears those flags by writing ones to them and gates the request line with an enable bit. A per-source armed flag records that the PLL has been locked at least once since reset. Software can drop that flag to make a PLL wait for a fresh lock before it is watched again. The register port is a plain single-cycle write strobe with a combinational read.

Top module: `pll_slip_monitor`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low. The registers are address 0 control, address 1 slip flags, address 2 armed flags and address 3 live lock view.
- R2: A PLL whose lock input has stayed low since reset never sets its slip flag, even with the interrupt enabled.
- R3: When an armed PLL's raw lock input falls, its slip flag at address 1 reads 1 after the third rising clock edge and not before. With the enable set, `irq_o` rises on that same edge.
- R4: The sources are independent. Bit 0 of the slip, armed and live registers belongs to the system PLL and bit 1 to the USB PLL. A loss on one source never sets the other source's bit.
- R5: A slip flag stays set after its PLL regains lock.
- R6: Writing 1 to a bit of address 1 clears that flag on the write edge, and writing 0 leaves it unchanged. If a new loss and a clearing write land on the same edge, the flag stays set.
- R7: `irq_o` is high exactly when control bit 0 (interrupt enable) is 1 and at least one slip flag is set. With the enable at 0, a loss sets its flag but `irq_o` stays low.
- R8: Writing 1 to control bit 0 while a slip flag is already set raises `irq_o` on the edge of that write.
- R9: The armed flag of a source reads 1 at address 2 from the third rising edge after its raw lock input rises. Writing 1 to a bit of address 2 clears that flag. A PLL that is unlocked and not armed raises no slip until it locks again.
- R10: Address 3 shows each source's synchronized lock level two rising edges after the raw input changes.
- R11: Writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_raw_i | input | NUM_SRC | Raw, possibly asynchronous lock indicators; bit 0 system PLL, bit 1 USB PLL |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 2 | Register select for read and write |
| reg_wdata_i | input | NUM_SRC | Write data, one bit per source (control uses bit 0) |
| reg_rdata_o | output | NUM_SRC | Combinational read data of the selected register |
| irq_o | output | 1 | Level interrupt request |

## Verification
A raw lock change shows in the live view two rising edges later. The armed flag and the slip flag follow one edge after that, which is the third edge. Register writes, including the enable, take effect on the edge that samples the strobe, and the interrupt follows combinationally on that same edge. The bench drives every input on a falling edge and counts rising edges before each directed check, sampling after the last edge that could change the result and also after the edge just before it. A cycle model in the bench updates on the same edges, and the random phase compares against it at every falling edge.

// File: rtl/pll_slip_pkg.sv
package pll_slip_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_SLIP = 2'd1,
    REG_ARM  = 2'd2,
    REG_LIVE = 2'd3
  } reg_sel_e;

  // A loss counts only for an armed source that was locked last cycle.
  function automatic logic loss_edge(input logic was_locked,
                                     input logic is_locked,
                                     input logic armed);
    return armed & was_locked & ~is_locked;
  endfunction

  // Sticky flag: a new event outranks a clearing write.
  function automatic logic sticky_next(input logic cur,
                                       input logic clr,
                                       input logic set);
    return set | (cur & ~clr);
  endfunction

  // Armed flag: software re-arm drops it, any locked cycle raises it.
  function automatic logic arm_next(input logic cur,
                                    input logic lock_now,
                                    input logic rearm);
    return rearm ? 1'b0 : (cur | lock_now);
  endfunction

endpackage

// File: rtl/pll_slip_sync.sv
module pll_slip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/pll_slip_tracker.sv
module pll_slip_tracker
  import pll_slip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic rearm_i,
  output logic armed_o,
  output logic slip_o
);

  logic was_q;
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      was_q   <= lock_i;
      armed_q <= arm_next(armed_q, lock_i, rearm_i);
    end
  end

  assign armed_o = armed_q;
  assign slip_o  = loss_edge(was_q, lock_i, armed_q);

endmodule

// File: rtl/pll_slip_regs.sv
module pll_slip_regs
  import pll_slip_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NUM_SRC-1:0]    wdata_i,
  input  logic [NUM_SRC-1:0]    slip_i,
  input  logic [NUM_SRC-1:0]    armed_i,
  input  logic [NUM_SRC-1:0]    live_i,
  output logic [NUM_SRC-1:0]    rdata_o,
  output logic                  irq_en_o,
  output logic [NUM_SRC-1:0]    status_o,
  output logic [NUM_SRC-1:0]    rearm_o
);

  logic hit_ctrl;
  logic hit_slip;
  logic hit_arm;
  logic en_q;
  logic [NUM_SRC-1:0] status_q;

  assign hit_ctrl = we_i && (addr_i == REG_CTRL);
  assign hit_slip = we_i && (addr_i == REG_SLIP);
  assign hit_arm  = we_i && (addr_i == REG_ARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (hit_ctrl) en_q <= wdata_i[0];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[g] <= 1'b0;
      else        status_q[g] <= sticky_next(status_q[g], hit_slip & wdata_i[g], slip_i[g]);
    end
  end

  assign rearm_o  = hit_arm ? wdata_i : '0;
  assign irq_en_o = en_q;
  assign status_o = status_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: rdata_o[0] = en_q;
      REG_SLIP: rdata_o    = status_q;
      REG_ARM:  rdata_o    = armed_i;
      REG_LIVE: rdata_o    = live_i;
      default:  rdata_o    = '0;
    endcase
  end

endmodule

// File: rtl/pll_slip_monitor.sv
module pll_slip_monitor
  import pll_slip_pkg::*;
#(
  parameter int NUM_SRC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    lock_raw_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [NUM_SRC-1:0]    reg_wdata_i,
  output logic [NUM_SRC-1:0]    reg_rdata_o,
  output logic                  irq_o
);

  // Named internal events, visible to the bound checker.
  logic [NUM_SRC-1:0] lock_sync;
  logic [NUM_SRC-1:0] armed;
  logic [NUM_SRC-1:0] slip_evt;
  logic [NUM_SRC-1:0] rearm;
  logic [NUM_SRC-1:0] status;
  logic               irq_en;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    pll_slip_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lock_raw_i[g]),
      .q_o   (lock_sync[g])
    );

    pll_slip_tracker u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock_i  (lock_sync[g]),
      .rearm_i (rearm[g]),
      .armed_o (armed[g]),
      .slip_o  (slip_evt[g])
    );
  end

  pll_slip_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .slip_i   (slip_evt),
    .armed_i  (armed),
    .live_i   (lock_sync),
    .rdata_o  (reg_rdata_o),
    .irq_en_o (irq_en),
    .status_o (status),
    .rearm_o  (rearm)
  );

  assign irq_o = irq_en & (|status);

endmodule

// File: rtl/pll_slip_monitor_chk.sv
module pll_slip_monitor_chk
  import pll_slip_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  irq_o,
  input logic                  irq_en,
  input logic [NUM_SRC-1:0]    status,
  input logic [NUM_SRC-1:0]    slip_evt,
  input logic [NUM_SRC-1:0]    armed,
  input logic [NUM_SRC-1:0]    lock_sync,
  input logic                  reg_we_i,
  input logic [REG_ADDR_W-1:0] reg_addr_i,
  input logic [NUM_SRC-1:0]    reg_wdata_i
);

  logic wr_slip;
  logic wr_arm;
  logic wr_ctrl;
  assign wr_slip = reg_we_i && (reg_addr_i == REG_SLIP);
  assign wr_arm  = reg_we_i && (reg_addr_i == REG_ARM);
  assign wr_ctrl = reg_we_i && (reg_addr_i == REG_CTRL);

  // R7: a disabled block never requests
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_o);

  // R8: enabling with a pending flag requests on the next edge
  p_enable_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata_i[0] && (|status)) |=> irq_o);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    // R2: an unarmed source cannot raise its flag
    p_unarmed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !armed[g] |=> !$rose(status[g]));

    // R3: a loss event lands in the flag
    p_loss_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      slip_evt[g] |=> status[g]);

    // R5: a flag holds unless software clears it
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status[g] && !(wr_slip && reg_wdata_i[g])) |=> status[g]);

    // R6: a clearing write without a new loss empties the flag
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_slip && reg_wdata_i[g] && !slip_evt[g]) |=> !status[g]);

    // R9: a locked cycle arms the source unless re-armed
    p_arm_on_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_sync[g] && !(wr_arm && reg_wdata_i[g])) |=> armed[g]);
  end

endmodule

bind pll_slip_monitor pll_slip_monitor_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_o       (irq_o),
  .irq_en      (irq_en),
  .status      (status),
  .slip_evt    (slip_evt),
  .armed       (armed),
  .lock_sync   (lock_sync),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i)
);

// File: tb/pll_slip_monitor_bench.sv
`timescale 1ns/1ps
module pll_slip_monitor_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lock = 2'b00;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [1:0] reg_wdata = 2'd0;
  logic [1:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pll_slip_monitor u_pll_slip_monitor (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_raw_i  (lock),
    .reg_we_i    (reg_we),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  // Cycle model built from the requirements.
  logic [1:0] m_s1, m_s2, m_prev, m_arm, m_st;
  logic       m_en;

  always @(posedge clk or negedge rst_n) begin
    logic [1:0] ev, clr, rearm;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_arm = 0; m_st = 0; m_en = 0;
    end else begin
      ev    = m_prev & ~m_s2 & m_arm;
      clr   = (reg_we && reg_addr == 2'd1) ? reg_wdata : 2'b00;
      rearm = (reg_we && reg_addr == 2'd2) ? reg_wdata : 2'b00;
      if (reg_we && reg_addr == 2'd0) m_en = reg_wdata[0];
      m_st   = (m_st & ~clr) | ev;
      m_arm  = (m_arm | m_s2) & ~rearm;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = lock;
    end
  end

  function automatic logic [1:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {1'b0, m_en};
      2'd1: return m_st;
      2'd2: return m_arm;
      default: return m_s2;
    endcase
  endfunction

  function automatic logic m_irq();
    return m_en & (|m_st);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [1:0] exp);
    reg_addr = a;
    #1;
    chk(tag, int'(rdata), int'(exp));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset values
    rd_chk("R1 ctrl", 2'd0, 2'd0);
    rd_chk("R1 slip", 2'd1, 2'd0);
    rd_chk("R1 armed", 2'd2, 2'd0);
    rd_chk("R1 live", 2'd3, 2'd0);
    chk("R1 irq", int'(irq), 0);

    // R2 never locked
    wr(2'd0, 2'd1);
    tick(10);
    rd_chk("R2 no slip", 2'd1, 2'd0);
    rd_chk("R2 not armed", 2'd2, 2'd0);
    chk("R2 irq", int'(irq), 0);

    // R10 / R9 lock latency on system PLL
    lock[0] = 1'b1;
    tick(1);
    rd_chk("R10 live early", 2'd3, 2'd0);
    tick(1);
    rd_chk("R10 live", 2'd3, 2'd1);
    rd_chk("R9 armed early", 2'd2, 2'd0);
    tick(1);
    rd_chk("R9 armed", 2'd2, 2'd1);

    // R3 loss latency
    tick(3);
    lock[0] = 1'b0;
    tick(2);
    rd_chk("R3 slip early", 2'd1, 2'd0);
    chk("R3 irq early", int'(irq), 0);
    tick(1);
    rd_chk("R3 slip", 2'd1, 2'd1);
    chk("R3 irq", int'(irq), 1);

    // R4 second source independent
    lock[1] = 1'b1;
    tick(4);
    rd_chk("R4 usb lock no slip", 2'd1, 2'd1);
    lock[1] = 1'b0;
    tick(3);
    rd_chk("R4 both", 2'd1, 2'd3);

    // R5 sticky across relock
    lock[0] = 1'b1;
    tick(6);
    rd_chk("R5 sticky", 2'd1, 2'd3);

    // R6 write-one-to-clear
    wr(2'd1, 2'd0);
    rd_chk("R6 zero write", 2'd1, 2'd3);
    wr(2'd1, 2'd1);
    rd_chk("R6 clear sys", 2'd1, 2'd2);
    chk("R7 irq usb pending", int'(irq), 1);
    wr(2'd1, 2'd2);
    rd_chk("R6 clear usb", 2'd1, 2'd0);
    chk("R7 irq idle", int'(irq), 0);

    // R7 disabled interrupt
    wr(2'd0, 2'd0);
    lock[0] = 1'b0;
    tick(4);
    rd_chk("R7 flag set", 2'd1, 2'd1);
    chk("R7 irq masked", int'(irq), 0);

    // R8 enable with pending flag
    wr(2'd0, 2'd1);
    chk("R8 irq immediate", int'(irq), 1);

    // R6 set wins over clear on the same edge
    lock[0] = 1'b1;
    tick(5);
    lock[0] = 1'b0;
    tick(2);
    wr(2'd1, 2'd1);
    rd_chk("R6 set wins", 2'd1, 2'd1);
    wr(2'd1, 2'd1);
    rd_chk("R6 cleared after", 2'd1, 2'd0);

    // R9 re-arm
    rd_chk("R9 both armed", 2'd2, 2'd3);
    wr(2'd2, 2'd1);
    rd_chk("R9 rearm sys", 2'd2, 2'd2);
    tick(5);
    rd_chk("R9 no slip unarmed", 2'd1, 2'd0);
    lock[0] = 1'b1;
    tick(3);
    rd_chk("R9 rearmed on lock", 2'd2, 2'd3);

    // R11 writes to live view ignored
    wr(2'd3, 2'd3);
    rd_chk("R11 ctrl kept", 2'd0, 2'd1);
    rd_chk("R11 slip kept", 2'd1, 2'd0);
    rd_chk("R11 armed kept", 2'd2, 2'd3);
    rd_chk("R11 live", 2'd3, 2'd1);

    // Random phase against the cycle model (R3 R4 R6 R7 R9)
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      chk("R7 random irq", int'(irq), int'(m_irq()));
      chk("R4 random read", int'(rdata), int'(m_read(reg_addr)));
      reg_we    = ($urandom % 6) == 0;
      reg_addr  = 2'($urandom % 4);
      reg_wdata = 2'($urandom % 4);
      if (($urandom % 16) == 0) lock[0] = ~lock[0];
      if (($urandom % 16) == 0) lock[1] = ~lock[1];
    end

    done = 1;
    summary();
    $finish;
  end

endmodule